// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block watches the current time of day, given as BCD minutes, hours and day from the timekeeping logic, and decides once per minute whether an alarm is due. Three host-writable alarm registers hold the target minute, hour and day. The top bit of each register is an "ignore this field" mask, so the host can choose how often the alarm fires: every minute, at a given minute of each hour, at a given time each day, or at a given day, hour and minute.

The comparison is made only when the timekeeping logic raises its one-cycle new-minute strobe. When every field either matches or is masked, the block gives a one-cycle match event and sets a sticky time-of-day flag. The flag stays set until the host reads or writes any of the three alarm registers through the simple address/write/read port.

Top module: `tod_alarm_cmp`

## Requirements
- R1: After synchronous reset the three alarm registers read 0x00, `tod_flag` is 0 and `match_pulse` is 0.
- R2: Address 0 selects the minute alarm, 1 the hour alarm, 2 the day alarm; a write stores all 8 bits and a read returns them combinationally on `host_rdata`. Address 3 reads 0x00 and a write to it changes no register.
- R3: Bit 7 of each alarm register is its mask and bits 6:0 its BCD value; a field counts as hit when its mask is 1 or its bits 6:0 equal the matching current-time input. Masks (min,hour,day) = (1,1,1) fire every minute, (0,1,1) on a minute match, (0,0,1) on hour and minute match, (0,0,0) on day, hour and minute match; every other combination treats each mask bit as an independent don't-care.
- R4: Comparison happens only in a cycle where `minute_tick` is 1; with `minute_tick` at 0 no match event occurs whatever the inputs.
- R5: When `minute_tick` is 1 and all three fields hit at a clock edge, `match_pulse` is 1 for exactly the following cycle.
- R6: A match sets `tod_flag` in the same cycle `match_pulse` rises, and the flag stays 1 until cleared.
- R7: A read or write of address 0, 1 or 2 clears `tod_flag` at that clock edge; an access to address 3 leaves it unchanged.
- R8: When a match and a clearing access fall in the same cycle, the match wins and `tod_flag` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| minute_tick | input | 1 | One-cycle new-minute strobe |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, BCD |
| now_day | input | 7 | Current day, BCD |
| host_addr | input | 2 | Register address |
| host_wr | input | 1 | Write enable |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| match_pulse | output | 1 | One-cycle alarm event |
| tod_flag | output | 1 | Sticky alarm flag |

## Verification
The assertions assume `minute_tick` is a single-cycle strobe, that the host never raises write and read in the same cycle, and that the time inputs are stable while the strobe is high. The bench drives every input on the falling edge, keeps strobe and host cycles to one clock each, and sweeps all eight mask combinations against all eight match/mismatch patterns of the three fields, clearing the flag through a register read before each tick.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
    localparam int BYTE_W     = 8;
    localparam int FIELD_W    = 7;
    localparam int NUM_FIELDS = 3;
    localparam int ADDR_W     = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MIN  = 2'd0,
        SEL_HOUR = 2'd1,
        SEL_DAY  = 2'd2,
        SEL_NONE = 2'd3
    } field_sel_e;

    typedef struct packed {
        logic               ignore;
        logic [FIELD_W-1:0] bcd;
    } alarm_field_t;

    function automatic logic field_hit(alarm_field_t cfg, logic [FIELD_W-1:0] now);
        return cfg.ignore || (cfg.bcd == now);
    endfunction
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
    import tod_alarm_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic                                wr,
    input  logic                                rd,
    input  logic [BYTE_W-1:0]                   wdata,
    output logic [BYTE_W-1:0]                   rdata,
    output alarm_field_t [NUM_FIELDS-1:0]       alarm_q,
    output logic                                clr_req
);
    logic sel_valid;
    assign sel_valid = (addr < ADDR_W'(NUM_FIELDS));
    assign clr_req   = (wr || rd) && sel_valid;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                alarm_q[g] <= '0;
            else if (wr && addr == ADDR_W'(g))
                alarm_q[g] <= alarm_field_t'(wdata);
        end

        // R2: a write to this field's address lands next cycle
        a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
            (wr && addr == ADDR_W'(g)) |=> (alarm_q[g] == $past(wdata)));
        // R2: a write elsewhere leaves the field untouched
        a_r2_other_addr_keeps: assert property (@(posedge clk) disable iff (rst)
            (wr && addr != ADDR_W'(g)) |=> $stable(alarm_q[g]));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (addr == ADDR_W'(i))
                rdata = alarm_q[i];
    end
endmodule

// File: rtl/tod_field_cmp.sv
module tod_field_cmp
    import tod_alarm_pkg::*;
(
    input  alarm_field_t        cfg,
    input  logic [FIELD_W-1:0]  now,
    output logic                hit
);
    assign hit = field_hit(cfg, now);
endmodule

// File: rtl/tod_alarm_event.sv
module tod_alarm_event (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic all_hit,
    input  logic clr_req,
    output logic match_pulse,
    output logic tod_flag
);
    logic fire;
    assign fire = tick && all_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_pulse <= 1'b0;
            tod_flag    <= 1'b0;
        end else begin
            match_pulse <= fire;
            if (fire)
                tod_flag <= 1'b1;
            else if (clr_req)
                tod_flag <= 1'b0;
        end
    end

    // R4: no event without the minute strobe
    a_r4_needs_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !match_pulse);
    // R6 and R8: an event always leaves the flag set
    a_r6_flag_with_pulse: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> tod_flag);
    // R7: a clearing access without an event drops the flag
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !fire) |=> !tod_flag);
    // R6: with neither event nor access the flag holds
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (!clr_req && !fire) |=> $stable(tod_flag));
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
    import tod_alarm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                minute_tick,
    input  logic [FIELD_W-1:0]  now_min,
    input  logic [FIELD_W-1:0]  now_hour,
    input  logic [FIELD_W-1:0]  now_day,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [BYTE_W-1:0]   host_wdata,
    output logic [BYTE_W-1:0]   host_rdata,
    output logic                match_pulse,
    output logic                tod_flag
);
    alarm_field_t [NUM_FIELDS-1:0]      alarm_q;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_v;
    logic [NUM_FIELDS-1:0]              hit_v;
    logic                               clr_req;

    assign now_v[SEL_MIN]  = now_min;
    assign now_v[SEL_HOUR] = now_hour;
    assign now_v[SEL_DAY]  = now_day;

    tod_alarm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (host_addr),
        .wr      (host_wr),
        .rd      (host_rd),
        .wdata   (host_wdata),
        .rdata   (host_rdata),
        .alarm_q (alarm_q),
        .clr_req (clr_req)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        tod_field_cmp u_cmp (
            .cfg (alarm_q[g]),
            .now (now_v[g]),
            .hit (hit_v[g])
        );
    end

    tod_alarm_event u_evt (
        .clk         (clk),
        .rst         (rst),
        .tick        (minute_tick),
        .all_hit     (&hit_v),
        .clr_req     (clr_req),
        .match_pulse (match_pulse),
        .tod_flag    (tod_flag)
    );

    // R3: a tick with every field masked always yields an event
    a_r3_all_masked_fires: assert property (@(posedge clk) disable iff (rst)
        (minute_tick && alarm_q[0].ignore && alarm_q[1].ignore && alarm_q[2].ignore)
        |=> match_pulse);
    // R5: the event lasts one cycle when ticks are isolated
    a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (match_pulse && !minute_tick) |=> !match_pulse);
endmodule

// File: tb/test_tod_alarm_cmp.sv
`timescale 1ns/1ps
module test_tod_alarm_cmp;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       minute_tick = 1'b0;
    logic [6:0] now_min = '0, now_hour = '0, now_day = '0;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       match_pulse, tod_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tod_alarm_cmp i_tod_alarm_cmp (
        .clk(clk), .rst(rst), .minute_tick(minute_tick),
        .now_min(now_min), .now_hour(now_hour), .now_day(now_day),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .match_pulse(match_pulse), .tod_flag(tod_flag)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // read: returns data sampled while the strobe is high
    task automatic host_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic tick(logic [6:0] m, logic [6:0] h, logic [6:0] dy);
        @(negedge clk);
        now_min = m; now_hour = h; now_day = dy; minute_tick = 1'b1;
        @(negedge clk);
        minute_tick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [6:0] am, ah, ad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 flag", tod_flag, 0);
        check("R1 pulse", match_pulse, 0);
        for (int a = 0; a < 3; a++) begin
            host_read(2'(a), rd);
            check("R1 reg", rd, 0);
        end

        // R2 readback and address 3
        host_write(2'd0, 8'hA5);
        host_write(2'd1, 8'h3C);
        host_write(2'd2, 8'h81);
        host_write(2'd3, 8'hFF);
        host_read(2'd0, rd); check("R2 min", rd, 8'hA5);
        host_read(2'd1, rd); check("R2 hour", rd, 8'h3C);
        host_read(2'd2, rd); check("R2 day", rd, 8'h81);
        host_read(2'd3, rd); check("R2 addr3", rd, 0);

        // R4: full match but no tick
        am = 7'h25; ah = 7'h13; ad = 7'h04;
        host_write(2'd0, {1'b0, am});
        host_write(2'd1, {1'b0, ah});
        host_write(2'd2, {1'b0, ad});
        @(negedge clk);
        now_min = am; now_hour = ah; now_day = ad;
        repeat (3) begin
            @(negedge clk);
            check("R4 no tick pulse", match_pulse, 0);
        end
        check("R4 no tick flag", tod_flag, 0);

        // R3 / R5 / R6 sweep: 8 mask combos x 8 match patterns
        for (int mk = 0; mk < 8; mk++) begin
            host_write(2'd0, {mk[0], am});
            host_write(2'd1, {mk[1], ah});
            host_write(2'd2, {mk[2], ad});
            for (int p = 0; p < 8; p++) begin
                logic [6:0] m, h, dy;
                bit exp;
                m  = p[0] ? am : 7'h26;
                h  = p[1] ? ah : 7'h07;
                dy = p[2] ? ad : 7'h05;
                exp = (mk[0] | p[0]) & (mk[1] | p[1]) & (mk[2] | p[2]);
                host_read(2'd0, rd);   // clears flag (R7)
                check("R7 read clears", tod_flag, 0);
                tick(m, h, dy);
                check("R3 R5 pulse", match_pulse, int'(exp));
                check("R6 flag set", tod_flag, int'(exp));
                @(negedge clk);
                check("R5 pulse one cycle", match_pulse, 0);
                check("R6 flag holds", tod_flag, int'(exp));
            end
        end

        // R7: address 3 does not clear, write to alarm address does
        host_write(2'd0, 8'h80); host_write(2'd1, 8'h80); host_write(2'd2, 8'h80);
        tick(7'h00, 7'h00, 7'h00);
        check("R3 every minute", tod_flag, 1);
        host_read(2'd3, rd);
        check("R7 addr3 read keeps", tod_flag, 1);
        host_write(2'd3, 8'h00);
        check("R7 addr3 write keeps", tod_flag, 1);
        host_write(2'd2, 8'h80);
        check("R7 write clears", tod_flag, 0);

        // R8: match and clearing read in the same cycle
        @(negedge clk);
        minute_tick = 1'b1; host_addr = 2'd1; host_rd = 1'b1;
        @(negedge clk);
        minute_tick = 1'b0; host_rd = 1'b0;
        check("R8 match wins pulse", match_pulse, 1);
        check("R8 match wins flag", tod_flag, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule